// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer

A general-purpose timer built around a 16-bit up-counter. The counter advances on a tick that comes from one of two sources. The first is the fast system clock divided by four. The second is a pulse train that a slow low-power clock delivers into the system clock domain. Either source then passes through a power-of-two prescaler.

Four independent channels watch the counter. A channel in capture mode latches the counter on a chosen edge of its input pin. A channel in compare mode raises an event when the counter reaches its value, and can toggle, clear or set its output pin at that moment. Every channel event and every counter wrap sets a sticky flag. Software clears a flag by writing a one to it. A mask selects which flags reach the interrupt vector.

When channel 3 is in compare mode and the auto-clear option is set, a match on channel 3 returns the counter to zero. The counter then runs with a programmable period. Clocked from the slow source, this makes the timer a periodic wake-up source.

The counter is sequenced by a small controller with three states:
- CS_HALT: the counter is frozen and the prescaler is cleared.
- CS_SYNC: one cycle in which the dividers start from zero.
- CS_RUN: ticks are generated.

Its transitions:
- CS_HALT goes to CS_SYNC when the enable bit is set.
- CS_SYNC goes to CS_RUN while the enable bit stays set, and back to CS_HALT if it is cleared.
- CS_RUN goes to CS_HALT when the enable bit is cleared.

Top module: `cc_timer`

## Requirements
- R1: After reset every register reads zero, the counter is halted, all compare outputs are low and the interrupt is deasserted.
- R2: With CTRL bit 0 (enable) set and CTRL bit 1 clear (fast source), the counter advances by one every 4·2^P clock cycles, where P is CTRL bits 4:2 (0 to 7).
- R3: While enable is clear the counter holds its value. A write to COUNT (address 0x1) loads the counter in any state.
- R4: A count tick at 0xFFFF wraps the counter to 0 and sets FLAGS bit 4.
- R5: A channel whose mode nibble (MODE bits 4n+3:4n) has kind bits [1:0] = 10 signals a match when a count tick occurs while the counter equals its value register (address 0x8+n). The match sets FLAGS bit n and applies the action given by the option bits [3:2]: 01 toggles, 10 clears and 11 sets the channel output.
- R6: With CTRL bit 5 set and channel 3 in compare mode, a channel-3 match returns the counter to 0. The period is then (V3+1) count ticks. With the bit clear the counter continues past V3.
- R7: With CTRL bit 1 set, each slow_tick_i pulse is one prescaler input, with no divide by four.
- R8: A channel with kind bits 01 captures on its synchronised input: option 01 selects the rising edge, 10 the falling edge and 11 both edges. On capture it latches the counter into its value register and sets FLAGS bit n. A channel with kind 00 ignores its input.
- R9: Writing FLAGS (address 0x3) clears each flag whose data bit is 1 and leaves the flags whose data bit is 0.
- R10: irq_vec_o is FLAGS masked by IRQEN (address 0x4, same bit layout), and irq_o is high when any bit of irq_vec_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| slow_tick_i | input | 1 | One-cycle pulse per period of the slow low-power clock |
| cap_i | input | 4 | Capture input pins, one per channel |
| cmp_o | output | 4 | Compare output pins, one per channel |
| irq_vec_o | output | 5 | Masked flags: channels in bits 3:0, wrap in bit 4 |
| irq_o | output | 1 | OR of irq_vec_o |

## Verification
The hardest case to reach from the ports is the channel-3 auto-clear period. It only shows as the spacing between two match events, and that spacing depends on the divider phase at which the counter was started. The bench therefore polls the interrupt vector every cycle, time-stamps two consecutive channel-3 flags, and compares their distance with the cycle count implied by the value, the prescaler and the clock source. Compare-pin actions are observed in the same loop. Capture cases freeze the counter at a loaded value, so that the latched value is known exactly whatever the synchroniser delay.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        CS_HALT = 2'd0,
        CS_SYNC = 2'd1,
        CS_RUN  = 2'd2
    } cnt_state_e;

    typedef enum logic [1:0] {
        CK_OFF  = 2'b00,
        CK_CAPT = 2'b01,
        CK_CMP  = 2'b10,
        CK_RSVD = 2'b11
    } ch_kind_e;

    localparam logic [1:0] OPT_TOGGLE = 2'b01;
    localparam logic [1:0] OPT_CLEAR  = 2'b10;
    localparam logic [1:0] OPT_SET    = 2'b11;

    localparam logic [ADDR_W-1:0] RA_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] RA_COUNT = 4'h1;
    localparam logic [ADDR_W-1:0] RA_MODE  = 4'h2;
    localparam logic [ADDR_W-1:0] RA_FLAGS = 4'h3;
    localparam logic [ADDR_W-1:0] RA_IRQEN = 4'h4;
    localparam logic [ADDR_W-1:0] RA_CHV0  = 4'h8;

endpackage

// File: rtl/cc_timer_tick.sv
module cc_timer_tick #(
    parameter int FAST_DIV = 4,
    parameter int EXP_W    = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             slow_sel_i,
    input  logic             slow_tick_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);

    localparam int PRE_W = (1 << EXP_W) - 1;

    logic             fast_tick;
    logic             base_tick;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;

    // fixed front divider for the fast source; absent when the divide is 1
    generate
        if (FAST_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(FAST_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FAST_DIV - 1);
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    div_q <= '0;
                end else if (!run_i || div_q == DIV_LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign fast_tick = run_i && (div_q == DIV_LAST);
        end else begin : g_nodiv
            assign fast_tick = run_i;
        end
    endgenerate

    assign base_tick = slow_sel_i ? (run_i && slow_tick_i) : fast_tick;

    // power-of-two prescaler: low bits of a free counter reach all ones
    assign pre_mask = (PRE_W'(1) << exp_i) - PRE_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (!run_i) begin
            pre_q <= '0;
        end else if (base_tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = base_tick && ((pre_q & pre_mask) == pre_mask);

endmodule

// File: rtl/cc_timer_count.sv
module cc_timer_count
    import cc_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_en_i,
    input  logic [CNT_W-1:0] clr_val_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    cnt_state_e       state_q;
    cnt_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_hit;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CS_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_HALT: if (enable_i) state_d = CS_SYNC;
            CS_SYNC: state_d = enable_i ? CS_RUN : CS_HALT;
            CS_RUN:  if (!enable_i) state_d = CS_HALT;
            default: state_d = CS_HALT;
        endcase
    end

    // outputs
    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            CS_HALT: run_o = 1'b0;
            CS_SYNC: run_o = 1'b0;
            CS_RUN:  run_o = 1'b1;
            default: run_o = 1'b0;
        endcase
    end

    assign clr_hit = tick_i && clr_en_i && (cnt_q == clr_val_i);
    assign wrap_o  = tick_i && !clr_hit && !load_i && (cnt_q == '1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (clr_hit) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
    import cc_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       kind_i,
    input  logic [1:0]       opt_i,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    input  logic             val_we_i,
    input  logic [CNT_W-1:0] val_wd_i,
    output logic [CNT_W-1:0] val_o,
    output logic             evt_o,
    output logic             pin_o
);

    logic [2:0]       sync_q;
    logic             rise;
    logic             fall;
    logic             cap_evt;
    logic             cmp_evt;
    logic [CNT_W-1:0] val_q;
    logic             pin_q;

    // two-stage synchroniser plus one stage of history for edge detection
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], pin_i};
        end
    end

    assign rise    = sync_q[1] && !sync_q[2];
    assign fall    = !sync_q[1] && sync_q[2];
    assign cap_evt = (kind_i == CK_CAPT) && ((opt_i[0] && rise) || (opt_i[1] && fall));
    assign cmp_evt = (kind_i == CK_CMP) && tick_i && (cnt_i == val_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            val_q <= '0;
        end else if (cap_evt) begin
            val_q <= cnt_i;
        end else if (val_we_i) begin
            val_q <= val_wd_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_q <= 1'b0;
        end else if (cmp_evt) begin
            unique case (opt_i)
                OPT_TOGGLE: pin_q <= !pin_q;
                OPT_CLEAR:  pin_q <= 1'b0;
                OPT_SET:    pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    assign val_o = val_q;
    assign evt_o = cap_evt || cmp_evt;
    assign pin_o = pin_q;

endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cc_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NCH      = 4,
    parameter int EXP_W    = 3,
    parameter int FAST_DIV = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    input  logic              bus_we_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    input  logic              slow_tick_i,
    input  logic [NCH-1:0]    cap_i,
    output logic [NCH-1:0]    cmp_o,
    output logic [NCH:0]      irq_vec_o,
    output logic              irq_o
);

    localparam int CTRL_W = EXP_W + 3;
    localparam int MODE_W = 4 * NCH;
    localparam int CLR_CH = NCH - 1;
    localparam int B_EN   = 0;
    localparam int B_SLOW = 1;
    localparam int B_EXP  = 2;
    localparam int B_CLR  = 2 + EXP_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [MODE_W-1:0] mode_q;
    logic [NCH:0]      flags_q;
    logic [NCH:0]      irqen_q;
    logic [NCH:0]      flag_clr;
    logic [NCH-1:0]    ch_evt;
    logic [CNT_W-1:0]  chv [NCH];
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_wr;
    logic              tick;
    logic              run;
    logic              wrap;
    logic              clr_en;

    // control registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            irqen_q <= '0;
        end else if (bus_we_i) begin
            if (bus_addr_i == RA_CTRL)  ctrl_q  <= bus_wdata_i[CTRL_W-1:0];
            if (bus_addr_i == RA_MODE)  mode_q  <= bus_wdata_i[MODE_W-1:0];
            if (bus_addr_i == RA_IRQEN) irqen_q <= bus_wdata_i[NCH:0];
        end
    end

    assign cnt_wr   = bus_we_i && (bus_addr_i == RA_COUNT);
    assign flag_clr = (bus_we_i && bus_addr_i == RA_FLAGS) ? bus_wdata_i[NCH:0] : '0;
    assign clr_en   = ctrl_q[B_CLR] && (mode_q[4*CLR_CH +: 2] == CK_CMP);

    // sticky flags, an event in the same cycle wins over the clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | {wrap, ch_evt};
        end
    end

    cc_timer_tick #(
        .FAST_DIV(FAST_DIV),
        .EXP_W   (EXP_W)
    ) tick_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .slow_sel_i (ctrl_q[B_SLOW]),
        .slow_tick_i(slow_tick_i),
        .exp_i      (ctrl_q[B_EXP +: EXP_W]),
        .tick_o     (tick)
    );

    cc_timer_count #(
        .CNT_W(CNT_W)
    ) count_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (ctrl_q[B_EN]),
        .tick_i    (tick),
        .load_i    (cnt_wr),
        .load_val_i(bus_wdata_i),
        .clr_en_i  (clr_en),
        .clr_val_i (chv[CLR_CH]),
        .run_o     (run),
        .cnt_o     (cnt_q),
        .wrap_o    (wrap)
    );

    generate
        for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
            cc_timer_chan #(
                .CNT_W(CNT_W)
            ) chan_i (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .kind_i  (mode_q[4*gi +: 2]),
                .opt_i   (mode_q[4*gi+2 +: 2]),
                .pin_i   (cap_i[gi]),
                .cnt_i   (cnt_q),
                .tick_i  (tick),
                .val_we_i(bus_we_i && (bus_addr_i == RA_CHV0 + ADDR_W'(gi))),
                .val_wd_i(bus_wdata_i),
                .val_o   (chv[gi]),
                .evt_o   (ch_evt[gi]),
                .pin_o   (cmp_o[gi])
            );
        end
    endgenerate

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            RA_CTRL:  bus_rdata_o = CNT_W'(ctrl_q);
            RA_COUNT: bus_rdata_o = cnt_q;
            RA_MODE:  bus_rdata_o = CNT_W'(mode_q);
            RA_FLAGS: bus_rdata_o = CNT_W'(flags_q);
            RA_IRQEN: bus_rdata_o = CNT_W'(irqen_q);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr_i == RA_CHV0 + ADDR_W'(i)) bus_rdata_o = chv[i];
                end
            end
        endcase
    end

    assign irq_vec_o = flags_q & irqen_q;
    assign irq_o     = |irq_vec_o;

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] cnt_q,
    input logic             tick,
    input logic             cnt_wr,
    input logic             clr_en,
    input logic [CNT_W-1:0] clr_val,
    input logic             run,
    input logic [NCH:0]     flags_q,
    input logic [NCH:0]     flag_clr,
    input logic             wrap
);

    // R2: apart from bus loads the counter only steps by one or returns to zero
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(cnt_q) && !$past(cnt_wr)) |->
            (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == '0));

    // R3: a halted counter keeps its value unless written
    a_r3_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !cnt_wr) |=> $stable(cnt_q));

    // R4: a tick at all ones sets the wrap flag
    a_r4_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_q == '1 && !cnt_wr && !(clr_en && cnt_q == clr_val)) |=> flags_q[NCH]);

    // R6: auto-clear returns the counter to zero on the channel-3 match
    a_r6_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_en && tick && cnt_q == clr_val && !cnt_wr) |=> (cnt_q == '0));

    // R9: write-one clears the wrap flag when no new wrap coincides
    a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr[NCH] && !wrap) |=> !flags_q[NCH]);

endmodule

bind cc_timer cc_timer_chk #(
    .CNT_W(CNT_W),
    .NCH  (NCH)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_q   (cnt_q),
    .tick    (tick),
    .cnt_wr  (cnt_wr),
    .clr_en  (clr_en),
    .clr_val (chv[NCH-1]),
    .run     (run),
    .flags_q (flags_q),
    .flag_clr(flag_clr),
    .wrap    (wrap)
);

// File: tb/cc_timer_tb_top.sv
`timescale 1ns/1ps
module cc_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        we = 1'b0;
    logic [15:0] rdata;
    logic        slow_tick = 1'b0;
    logic        slow_en = 1'b0;
    logic [3:0]  cap = '0;
    logic [3:0]  cmp;
    logic [4:0]  ivec;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int slow_cnt = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cc_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_we_i(we), .bus_rdata_o(rdata), .slow_tick_i(slow_tick),
        .cap_i(cap), .cmp_o(cmp), .irq_vec_o(ivec), .irq_o(irq)
    );

    // slow clock pulses: one every 10 system cycles
    initial begin
        forever begin
            @(negedge clk);
            slow_cnt = (slow_cnt == 9) ? 0 : slow_cnt + 1;
            slow_tick = slow_en && (slow_cnt == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_vec(input int b, input int limit, output int t);
        t = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            #1;
            if (ivec[b]) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(4'h0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(4'h1, v); chk(v == 0, "R1 count", v, 0);
        rd(4'h3, v); chk(v == 0, "R1 flags", v, 0);
        chk(cmp == 0 && irq == 0, "R1 outputs", {cmp, irq}, 0);
    endtask

    task automatic t_rate();
        logic [15:0] a, b;
        wr(4'h4, 16'h001F);
        wr(4'h1, 16'h0100);
        repeat (20) @(negedge clk);
        rd(4'h1, a); chk(a == 16'h0100, "R3 load and hold", a, 16'h0100);
        wr(4'h0, 16'h0001);
        repeat (10) @(negedge clk);
        rd(4'h1, a); repeat (39) @(negedge clk); rd(4'h1, b);
        chk(b - a == 10, "R2 rate P=0", b - a, 10);
        wr(4'h0, 16'h000D);
        repeat (40) @(negedge clk);
        rd(4'h1, a); repeat (319) @(negedge clk); rd(4'h1, b);
        chk(b - a == 10, "R2 rate P=3", b - a, 10);
        wr(4'h0, 16'h0000);
        rd(4'h1, a); repeat (50) @(negedge clk); rd(4'h1, b);
        chk(a == b, "R3 halted hold", b, a);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        int t;
        wr(4'h3, 16'h001F);
        wr(4'h1, 16'hFFFE);
        wr(4'h0, 16'h0001);
        wait_vec(4, 100, t);
        chk(t >= 0, "R4 wrap flag", ivec, 5'h10);
        rd(4'h1, v); chk(v < 16'h0010, "R4 wrapped count", v, 0);
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'h000F);
        rd(4'h3, v);
        chk(v[4] && !irq, "R10 masked flag", {v[4], irq}, 2'b10);
        wr(4'h4, 16'h001F);
        chk(irq == 1'b1, "R10 unmasked irq", irq, 1);
        wr(4'h3, 16'h0000);
        chk(ivec[4] == 1'b1, "R9 write zero keeps", ivec[4], 1);
        wr(4'h3, 16'h0010);
        chk(ivec[4] == 1'b0, "R9 write one clears", ivec[4], 0);
    endtask

    task automatic t_compare();
        logic [15:0] v;
        int t0, t1;
        wr(4'h1, 16'h0000);
        wr(4'hB, 16'd9);
        wr(4'h8, 16'd2);
        wr(4'h2, 16'h2006);          // ch3 compare, ch0 compare toggle
        wr(4'h3, 16'h001F);
        wr(4'h0, 16'h0025);          // enable, P=1, auto-clear
        wait_vec(3, 500, t0);
        chk(cmp[0] == 1'b1, "R5 toggle first", cmp[0], 1);
        wr(4'h3, 16'h000F);
        wait_vec(3, 500, t1);
        chk(t0 >= 0 && t1 - t0 == 80, "R6 period", t1 - t0, 80);
        chk(cmp[0] == 1'b0, "R5 toggle second", cmp[0], 0);
        wr(4'h2, 16'h200E);          // ch0 set
        wr(4'h3, 16'h000F);
        wait_vec(0, 500, t0);
        chk(t0 >= 0 && cmp[0] == 1'b1, "R5 set action", cmp[0], 1);
        wr(4'h2, 16'h200A);          // ch0 clear
        wr(4'h3, 16'h000F);
        wait_vec(0, 500, t0);
        repeat (2) @(negedge clk);
        chk(t0 >= 0 && cmp[0] == 1'b0, "R5 clear action", cmp[0], 0);
        wr(4'h0, 16'h0000);
        wr(4'h1, 16'h0000);
        wr(4'hB, 16'd3);
        wr(4'h0, 16'h0001);          // no auto-clear
        repeat (60) @(negedge clk);
        rd(4'h1, v); chk(v > 16'd4, "R6 no clear passes V3", v, 5);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_slow();
        int t0, t1;
        wr(4'h1, 16'h0000);
        wr(4'h2, 16'h2000);
        wr(4'hB, 16'd4);
        wr(4'h3, 16'h001F);
        slow_en = 1'b1;
        wr(4'h0, 16'h0023);          // enable, slow source, auto-clear
        wait_vec(3, 500, t0);
        wr(4'h3, 16'h000F);
        wait_vec(3, 500, t1);
        chk(t0 >= 0 && t1 - t0 == 50, "R7 slow period", t1 - t0, 50);
        wr(4'h0, 16'h0000);
        slow_en = 1'b0;
    endtask

    task automatic t_capture();
        logic [15:0] v;
        wr(4'h1, 16'h1234);
        wr(4'h2, 16'h0050);          // ch1 capture rising
        wr(4'h3, 16'h001F);
        cap[1] = 1'b1; repeat (5) @(negedge clk); #1;
        chk(ivec[1] == 1'b1, "R8 rising flag", ivec[1], 1);
        rd(4'h9, v); chk(v == 16'h1234, "R8 rising value", v, 16'h1234);
        wr(4'h3, 16'h0002);
        cap[1] = 1'b0; repeat (5) @(negedge clk); #1;
        chk(ivec[1] == 1'b0, "R8 falling ignored", ivec[1], 0);
        wr(4'h2, 16'h0090);          // ch1 capture falling
        wr(4'h1, 16'h0042);
        cap[1] = 1'b1; repeat (5) @(negedge clk); #1;
        chk(ivec[1] == 1'b0, "R8 rising ignored", ivec[1], 0);
        cap[1] = 1'b0; repeat (5) @(negedge clk); #1;
        chk(ivec[1] == 1'b1, "R8 falling flag", ivec[1], 1);
        rd(4'h9, v); chk(v == 16'h0042, "R8 falling value", v, 16'h0042);
        wr(4'h2, 16'h00D0);          // ch1 both edges
        wr(4'h3, 16'h0002);
        cap[1] = 1'b1; repeat (5) @(negedge clk); #1;
        chk(ivec[1] == 1'b1, "R8 both rise", ivec[1], 1);
        wr(4'h3, 16'h0002);
        cap[1] = 1'b0; repeat (5) @(negedge clk); #1;
        chk(ivec[1] == 1'b1, "R8 both fall", ivec[1], 1);
        wr(4'hA, 16'h0055);          // ch2 off
        cap[2] = 1'b1; repeat (5) @(negedge clk);
        cap[2] = 1'b0; repeat (5) @(negedge clk); #1;
        chk(ivec[2] == 1'b0, "R8 off flag", ivec[2], 0);
        rd(4'hA, v); chk(v == 16'h0055, "R8 off value", v, 16'h0055);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate();
        t_wrap();
        t_compare();
        t_slow();
        t_capture();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule